// File: doc/BRIEF.md
# Programmable Horizontal Scan Timing Generator

This block produces the horizontal timing of a display controller. It runs on the pixel clock and keeps two counters. The first counts the eight pixels of a character cell. The second counts character cells across the scan line. A small register port loads six 16-bit character positions and a 2-bit sync delay code. These positions set the line length, the visible width, the blanking window and the sync window.

Every position uses a value-plus-one encoding. A line whose total register is N lasts (N+1)*8 pixels, and a window edge written as K falls on character K+1. Writes first go into a shadow copy. That copy moves into the working set only at the wrap from the last pixel of a line to the first pixel of the next, so a line never mixes two settings. The decoded outputs are display enable, blank, hsync, a one-cycle end-of-line strobe and the current character index. They follow the counter state combinationally.

Top module: `htiming_gen`

## Requirements
- R1: While `rst_n` is low, all seven settings clear to 0 and both counters clear to 0. During reset the outputs read `display_en`=1, `blank`=0, `hsync`=0, `eol`=0 and `char_pos`=0.
- R2: A line lasts (total+1)*8 pixel clocks. `eol` is high for exactly one clock, on the last pixel of the line, which is pixel 7 of character `total`. `char_pos` gives the character index from 0 to total.
- R3: `display_en` is high for characters 0 through `disp`, which is the first (disp+1)*8 pixels of the line.
- R4: `blank` is high for characters c with bstart < c <= bend. When bend <= bstart, `blank` stays low for the whole line.
- R5: When the delay code is not 2, `hsync` is high for characters c with sstart < c <= send, and it is aligned to character boundaries.
- R6: When the delay code is 2, `hsync` is the R5 window moved 4 pixels later. In pixels 0 to 3 of a character, `hsync` shows the undelayed value of the previous character. At character 0 this is the last character of the previous line.
- R7: A write changes only the shadow copy. The current line finishes with the old settings, and the new ones apply from the first pixel of the next line.
- R8: `wr_sel` selects the register being written: 0 total, 1 disp, 2 bstart, 3 bend, 4 sstart, 5 send, 6 delay code. Selects 0 to 5 take all 16 bits of `wr_data`. Select 6 takes the delay code from `wr_data[6:5]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (R8 encoding) |
| wr_data | input | 16 | Write data |
| display_en | output | 1 | Active picture region |
| blank | output | 1 | Blanking window |
| hsync | output | 1 | Horizontal sync, optionally delayed half a character |
| eol | output | 1 | One-cycle strobe on the last pixel of a line |
| char_pos | output | 16 | Current character index within the line |

## Verification
Two of the block's actions can land in the same cycle, and the bench provokes both. In the first, the counter wraps to a new line while the delayed sync still carries the previous line's last character. To provoke it, the sync window is set to end on the final character with the delay code at 2, and the bench checks that `hsync` stays high through pixels 0 to 3 of character 0 and then drops. In the second, a register write arrives while a line is in progress. To provoke it, the visible width is rewritten on pixel 0 of a line, and the bench checks that `display_en` keeps the old width for the rest of that line and takes the new width exactly on the next line.

// File: rtl/htg_pkg.sv
`timescale 1ns/1ps
// Shared widths, register selects and the timing configuration record.
package htg_pkg;
    parameter int POS_W        = 16;   // width of every position register
    parameter int PIX_PER_CHAR = 8;    // pixels per character cell
    parameter int DLY_W        = 2;    // sync delay code width
    parameter int DLY_LSB      = 5;    // delay code position in write data
    localparam int PIX_W       = $clog2(PIX_PER_CHAR);
    localparam int HALF_CHAR   = PIX_PER_CHAR / 2;
    localparam logic [DLY_W-1:0] DLY_HALF = 2'd2;

    typedef enum logic [2:0] {
        SEL_TOTAL  = 3'd0,
        SEL_DISP   = 3'd1,
        SEL_BSTART = 3'd2,
        SEL_BEND   = 3'd3,
        SEL_SSTART = 3'd4,
        SEL_SEND   = 3'd5,
        SEL_DELAY  = 3'd6
    } htg_sel_e;

    typedef struct packed {
        logic [POS_W-1:0] total;
        logic [POS_W-1:0] disp;
        logic [POS_W-1:0] bstart;
        logic [POS_W-1:0] bend;
        logic [POS_W-1:0] sstart;
        logic [POS_W-1:0] send;
        logic [DLY_W-1:0] sdly;
    } htg_cfg_t;
endpackage

// File: rtl/htg_regs.sv
`timescale 1ns/1ps
// Shadow and working copies of the timing settings.
// Writes land in the shadow copy; the working copy follows it only on load,
// which the counter raises on the last pixel of a line.
// Assumes load is a single-cycle strobe.
module htg_regs
    import htg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [POS_W-1:0] wr_data,
    input  logic             load,
    output htg_cfg_t         cfg
);
    htg_cfg_t shadow;

    // Capture software writes into the shadow copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (wr_en) begin
            case (htg_sel_e'(wr_sel))
                SEL_TOTAL:  shadow.total  <= wr_data;
                SEL_DISP:   shadow.disp   <= wr_data;
                SEL_BSTART: shadow.bstart <= wr_data;
                SEL_BEND:   shadow.bend   <= wr_data;
                SEL_SSTART: shadow.sstart <= wr_data;
                SEL_SEND:   shadow.send   <= wr_data;
                SEL_DELAY:  shadow.sdly   <= wr_data[DLY_LSB +: DLY_W];
                default:    shadow        <= shadow;
            endcase
        end
    end

    // Promote the shadow copy at the line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n)    cfg <= '0;
        else if (load) cfg <= shadow;
    end

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg));
endmodule

// File: rtl/htg_counter.sv
`timescale 1ns/1ps
// Pixel-within-character and character-within-line counters.
// The line wraps after pixel PIX_PER_CHAR-1 of character `total`, and the
// eol strobe marks that last pixel. Assumes total changes only at the wrap.
module htg_counter
    import htg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [POS_W-1:0] total,
    output logic [POS_W-1:0] char_cnt,
    output logic [PIX_W-1:0] pix_cnt,
    output logic             eol
);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_CHAR - 1);

    logic char_end;

    // Flag the last pixel of a character and of a line.
    always_comb begin
        char_end = (pix_cnt == PIX_LAST);
        eol      = char_end && (char_cnt == total);
    end

    // Advance the pixel and character counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt  <= '0;
            char_cnt <= '0;
        end else begin
            pix_cnt <= char_end ? '0 : pix_cnt + 1'b1;
            if (eol)           char_cnt <= '0;
            else if (char_end) char_cnt <= char_cnt + 1'b1;
        end
    end

    // R2
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eol |=> (char_cnt == '0 && pix_cnt == '0));
    // R2
    char_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_cnt <= total);
endmodule

// File: rtl/htg_decode.sv
`timescale 1ns/1ps
// Compares the counters with the working settings to form display enable,
// blank and hsync. The half-character sync delay uses the undelayed sync
// of the previous character, held in a register, for pixels 0..HALF_CHAR-1.
// Assumes the settings change only at the line wrap.
module htg_decode
    import htg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  htg_cfg_t         cfg,
    input  logic [POS_W-1:0] char_cnt,
    input  logic [PIX_W-1:0] pix_cnt,
    output logic             display_en,
    output logic             blank,
    output logic             hsync
);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(PIX_PER_CHAR - 1);
    localparam logic [PIX_W-1:0] PIX_HALF = PIX_W'(HALF_CHAR);

    logic sync_raw;
    logic sync_prev;

    // Window compares with the value-plus-one encoding.
    always_comb begin
        display_en = (char_cnt <= cfg.disp);
        blank      = (char_cnt > cfg.bstart) && (char_cnt <= cfg.bend);
        sync_raw   = (char_cnt > cfg.sstart) && (char_cnt <= cfg.send);
        if (cfg.sdly == DLY_HALF && pix_cnt < PIX_HALF) hsync = sync_prev;
        else                                           hsync = sync_raw;
    end

    // Remember the undelayed sync of the character just finishing.
    always_ff @(posedge clk) begin
        if (!rst_n)                 sync_prev <= 1'b0;
        else if (pix_cnt == PIX_LAST) sync_prev <= sync_raw;
    end

    // R4
    blank_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_cnt != '0) |-> $stable(blank));
    // R5
    sync_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sdly != DLY_HALF && pix_cnt != '0) |-> $stable(hsync));
    // R6
    sync_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sdly == DLY_HALF && pix_cnt != '0 && pix_cnt != PIX_HALF)
            |-> $stable(hsync));
endmodule

// File: rtl/htiming_gen.sv
`timescale 1ns/1ps
// Top of the horizontal timing generator: register port, counters and
// window decoding. Runs entirely on the pixel clock.
module htiming_gen
    import htg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [POS_W-1:0] wr_data,
    output logic             display_en,
    output logic             blank,
    output logic             hsync,
    output logic             eol,
    output logic [POS_W-1:0] char_pos
);
    htg_cfg_t         cfg;
    logic [PIX_W-1:0] pix_cnt;

    htg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (eol),
        .cfg     (cfg)
    );

    htg_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .total    (cfg.total),
        .char_cnt (char_pos),
        .pix_cnt  (pix_cnt),
        .eol      (eol)
    );

    htg_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .char_cnt   (char_pos),
        .pix_cnt    (pix_cnt),
        .display_en (display_en),
        .blank      (blank),
        .hsync      (hsync)
    );
endmodule

// File: tb/htiming_gen_test.sv
`timescale 1ns/1ps
module htiming_gen_test;
    import htg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        display_en, blank, hsync, eol;
    logic [15:0] char_pos;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    htiming_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .display_en(display_en), .blank(blank),
        .hsync(hsync), .eol(eol), .char_pos(char_pos)
    );

    always #2.5 clk = ~clk;

    // Vectors: total, disp, bstart, bend, sstart, send, delay code
    localparam htg_cfg_t VEC [5] = '{
        '{16'd9,  16'd5,  16'd6, 16'd8,  16'd6,  16'd7,  2'd0},
        '{16'd9,  16'd5,  16'd6, 16'd8,  16'd6,  16'd7,  2'd2},
        '{16'd0,  16'd0,  16'd0, 16'd0,  16'd0,  16'd0,  2'd0},
        '{16'd12, 16'd12, 16'd3, 16'd1,  16'd10, 16'd12, 2'd2},
        '{16'd15, 16'd7,  16'd8, 16'd15, 16'd9,  16'd11, 2'd1}
    };

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit in_win(input int lo, input int hi, input int c);
        return (c > lo) && (c <= hi);
    endfunction

    task automatic write_reg(input int sel, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_cfg(input htg_cfg_t c);
        write_reg(0, c.total);  write_reg(1, c.disp);
        write_reg(2, c.bstart); write_reg(3, c.bend);
        write_reg(4, c.sstart); write_reg(5, c.send);
        write_reg(6, int'(c.sdly) << DLY_LSB);   // R8 delay code in bits 6:5
    endtask

    task automatic wait_eol();
        do @(negedge clk); while (!eol);
    endtask

    // Check every pixel of one line; optional write driven on pixel 0.
    task automatic check_line(input htg_cfg_t c, input bit do_wr,
                              input int wsel, input int wdata);
        int len;
        len = (int'(c.total) + 1) * 8;
        for (int i = 0; i < len; i++) begin
            int ch, px;
            bit sraw, sexp;
            @(negedge clk);
            if (do_wr && i == 0) begin
                wr_en = 1'b1; wr_sel = 3'(wsel); wr_data = 16'(wdata);
            end else wr_en = 1'b0;
            ch = i / 8; px = i % 8;
            sraw = in_win(c.sstart, c.send, ch);
            if (c.sdly == 2'd2 && px < 4)
                sexp = (ch == 0) ? in_win(c.sstart, c.send, c.total)
                                 : in_win(c.sstart, c.send, ch - 1);
            else sexp = sraw;
            chk("R2", "char_pos", char_pos, ch);
            chk("R2", "eol", eol, (i == len - 1));
            chk(do_wr ? "R7" : "R3", "display_en", display_en, ch <= c.disp);
            chk("R4", "blank", blank, in_win(c.bstart, c.bend, ch));
            chk(c.sdly == 2'd2 ? "R6" : "R5", "hsync", hsync, sexp);
        end
        wr_en = 1'b0;
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        htg_cfg_t mod;
        int k;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "display_en", display_en, 1);
        chk("R1", "blank", blank, 0);
        chk("R1", "hsync", hsync, 0);
        chk("R1", "eol", eol, 0);
        chk("R1", "char_pos", char_pos, 0);
        rst_n = 1'b1;
        // R2 with reset settings the line is one character: eol every 8 clocks
        k = 0;
        do begin @(negedge clk); k++; end while (!eol && k < 20);
        chk("R2", "first eol offset", k, 7);
        k = 0;
        do begin @(negedge clk); k++; end while (!eol && k < 20);
        chk("R2", "eol period", k, 8);

        // Vector walk
        for (int v = 0; v < 5; v++) begin
            write_cfg(VEC[v]);
            wait_eol();
            wait_eol();
            check_line(VEC[v], 1'b0, 0, 0);
        end

        // R7 mid-line write: old width holds this line, new width next line
        write_cfg(VEC[0]);
        wait_eol();
        wait_eol();
        check_line(VEC[0], 1'b1, 1, 2);
        mod = VEC[0];
        mod.disp = 16'd2;
        check_line(mod, 1'b0, 0, 0);

        // R8 unused select 7 changes nothing
        write_reg(7, 16'hFFFF);
        wait_eol();
        wait_eol();
        check_line(mod, 1'b0, 0, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule